// File: doc/BRIEF.md
# Zero-turnaround synchronous burst SRAM

A single-port synchronous SRAM model for on-chip use. Address and control are sampled on the rising clock edge; read data flows straight from the array to the data outputs in the cycle that follows that edge. Write data is taken one enabled edge after its address. This lets a read follow a write, or a write follow a read, on consecutive cycles with no idle slot on the bus.

A low load strobe starts an operation at the presented address. A high load strobe steps an internal two-bit beat counter through the four words of the aligned group instead. The order of those words is either wrapping increment or offset XOR beat count, chosen by an order select that is sampled at each load. Three chip selects, with mixed polarities, gate new operations. A global clock enable freezes the whole block, and an asynchronous output enable can turn the output drivers off at any time. The bus is split into an input vector, an output vector and a drive-enable output that controls the pad driver.

Top module: `zbt_sram`

## Requirements
- R1: After reset release, and with no operation started, dq_oe_o is 0.
- R2: A load (load_ni=0, chip selected, wr_ni=1) registered at a clock edge shows the addressed word on dq_o with dq_oe_o=1 in the cycle directly after that edge.
- R3: Write data is taken from dq_i at the next enabled edge after the write beat is registered. byte_wr_ni bit k=0 lets lane k (bits 9k+8..9k) be written; bit k=1 keeps the stored lane.
- R4: With order_i=0 at the load, beat n addresses low bits (start+n) mod 4 of the loaded group, where start is addr_i[1:0].
- R5: With order_i=1 at the load, beat n addresses low bits start XOR n.
- R6: While clk_en_ni=1, all synchronous inputs are ignored: the current beat, its data output and any write data still to be taken are held until the next enabled edge.
- R7: A load with cs_a_ni=1, cs_b_i=0 or cs_c_ni=1 starts nothing: dq_oe_o is 0 in the next cycle and later advance strobes do nothing, while a write beat already registered still takes its data at that edge.
- R8: A write followed on the very next cycle by a read of the same address returns the newly written data.
- R9: oe_ni=1 forces dq_oe_o to 0 without waiting for a clock edge.
- R10: dq_oe_o is 0 in the cycle after a write is registered.
- R11: Advancing past the fourth beat wraps the counter, so the fifth beat repeats the first address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_ni | input | 1 | Clock enable, active low |
| cs_a_ni | input | 1 | Chip select, active low |
| cs_b_i | input | 1 | Chip select, active high |
| cs_c_ni | input | 1 | Chip select, active low |
| load_ni | input | 1 | 0 loads a new address, 1 advances the burst |
| wr_ni | input | 1 | 0 write, 1 read, sampled at load |
| byte_wr_ni | input | 4 | Per-lane write select, active low |
| addr_i | input | 8 | Word address |
| order_i | input | 1 | Burst order: 0 increment, 1 XOR |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| dq_i | input | 36 | Write data from the bus |
| dq_o | output | 36 | Read data to the bus |
| dq_oe_o | output | 1 | Bus driver enable |

## Verification
Two events can land in the same cycle: taking the data of a pending write and registering the next beat, which may be a read of that very word, a deselect or a stalled edge. The bench sets up each of these pairs back to back: write then read of the same address, write then deselect, and write then stall then read. It judges them by the word and the drive enable seen on the bus in the following cycle, compared against a bench-side copy of the array.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;

  function automatic logic [1:0] beat_ofs(burst_order_e ord, logic [1:0] start, logic [1:0] cnt);
    return (ord == ORD_INTERLEAVE) ? (start ^ cnt) : (start + cnt);
  endfunction
endpackage

// File: rtl/zbt_burst_ctr.sv
module zbt_burst_ctr
  import zbt_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic [AW-1:0] addr_i,
  input  logic          order_i,
  output logic [AW-1:0] beat_addr_o
);
  logic [AW-3:0] base_q;
  logic [1:0]    ofs_q, cnt_q;
  burst_order_e  ord_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      ofs_q  <= '0;
      cnt_q  <= '0;
      ord_q  <= ORD_LINEAR;
    end else if (en_i) begin
      if (load_i) begin
        base_q <= addr_i[AW-1:2];
        ofs_q  <= addr_i[1:0];
        cnt_q  <= '0;
        ord_q  <= burst_order_e'(order_i);
      end else if (adv_i) begin
        cnt_q <= cnt_q + 2'd1;
      end
    end
  end

  assign beat_addr_o = {base_q, beat_ofs(ord_q, ofs_q, cnt_q)};

  // R4
  adv_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i && adv_i) |=> (cnt_q == $past(cnt_q) + 2'd1));

  // R5
  load_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && load_i) |=> ((cnt_q == 2'd0) && (ofs_q == $past(addr_i[1:0]))));
endmodule

// File: rtl/zbt_lane_mem.sv
module zbt_lane_mem #(
  parameter int AW = 8,
  parameter int W  = 9
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  // flow-through: combinational read of the current beat
  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clk_en_ni,
  input  logic                    cs_a_ni,
  input  logic                    cs_b_i,
  input  logic                    cs_c_ni,
  input  logic                    load_ni,
  input  logic                    wr_ni,
  input  logic [LANES-1:0]        byte_wr_ni,
  input  logic [AW-1:0]           addr_i,
  input  logic                    order_i,
  input  logic                    oe_ni,
  input  logic [LANES*LANE_W-1:0] dq_i,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic                    dq_oe_o
);
  localparam int DW = LANES * LANE_W;

  logic             en, sel_ok, start, adv;
  logic             act_q, wr_q;
  logic [LANES-1:0] be_q;
  logic [AW-1:0]    beat_addr;
  logic [DW-1:0]    rdata;

  assign en     = !clk_en_ni;
  assign sel_ok = !cs_a_ni && cs_b_i && !cs_c_ni;
  assign start  = !load_ni && sel_ok;
  assign adv    = load_ni && act_q;

  // current beat; a write beat stays pending until the next enabled edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      wr_q  <= 1'b0;
      be_q  <= '0;
    end else if (en) begin
      if (!load_ni) act_q <= sel_ok;
      if (start) wr_q <= !wr_ni;
      if (start || adv) be_q <= ~byte_wr_ni;
    end
  end

  zbt_burst_ctr #(.AW(AW)) u_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en),
    .load_i      (start),
    .adv_i       (adv),
    .addr_i      (addr_i),
    .order_i     (order_i),
    .beat_addr_o (beat_addr)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    zbt_lane_mem #(.AW(AW), .W(LANE_W)) u_mem (
      .clk_i   (clk_i),
      .we_i    (en && act_q && wr_q && be_q[k]),
      .addr_i  (beat_addr),
      .wdata_i (dq_i[k*LANE_W +: LANE_W]),
      .rdata_o (rdata[k*LANE_W +: LANE_W])
    );
  end

  assign dq_o    = rdata;
  assign dq_oe_o = act_q && !wr_q && !oe_ni;

  // R7
  desel_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !load_ni && !sel_ok) |=> !dq_oe_o);

  // R10
  wr_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && start && !wr_ni) |=> !dq_oe_o);

  // R6
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> ($stable(act_q) && $stable(wr_q) && $stable(beat_addr)));
endmodule

// File: tb/zbt_sram_tb.sv
module zbt_sram_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clk_en_ni = 1'b0, cs_a_ni = 1'b0, cs_b_i = 1'b1, cs_c_ni = 1'b0;
  logic        load_ni = 1'b1, wr_ni = 1'b1, order_i = 1'b0, oe_ni = 1'b0;
  logic [3:0]  byte_wr_ni = 4'hf;
  logic [7:0]  addr_i = '0;
  logic [35:0] dq_i = '0, dq_o;
  logic        dq_oe_o;
  int          n_chk = 0, n_err = 0;
  logic [35:0] ref_m [256];

  always #5 clk = ~clk;

  zbt_sram u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .clk_en_ni(clk_en_ni), .cs_a_ni(cs_a_ni),
    .cs_b_i(cs_b_i), .cs_c_ni(cs_c_ni), .load_ni(load_ni), .wr_ni(wr_ni),
    .byte_wr_ni(byte_wr_ni), .addr_i(addr_i), .order_i(order_i), .oe_ni(oe_ni),
    .dq_i(dq_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o)
  );

  function automatic logic [35:0] mk(input logic [7:0] a, input logic [35:0] s);
    return {4{a, 1'b1}} ^ s;
  endfunction

  // desel: 0 selected, 1 cs_a off, 2 cs_b off, 3 cs_c off
  task automatic step(input logic ld_n, input logic w_n, input logic [7:0] a,
                      input logic [3:0] b_n, input int desel, input logic stall,
                      input logic [35:0] d);
    load_ni = ld_n; wr_ni = w_n; addr_i = a; byte_wr_ni = b_n;
    cs_a_ni = (desel == 1); cs_b_i = (desel != 2); cs_c_ni = (desel == 3);
    clk_en_ni = stall; dq_i = d;
    @(posedge clk); #2;
  endtask

  task automatic chk_rd(input string tag, input logic [35:0] exp);
    n_chk++;
    if (!dq_oe_o || dq_o !== exp) begin
      n_err++;
      $display("FAIL %s: oe=%0b dq=%h expected oe=1 dq=%h", tag, dq_oe_o, dq_o, exp);
    end
  endtask

  task automatic chk_off(input string tag);
    n_chk++;
    if (dq_oe_o !== 1'b0) begin
      n_err++;
      $display("FAIL %s: oe=%0b expected oe=0", tag, dq_oe_o);
    end
  endtask

  // linear write burst over an aligned group, data mk(addr, 0)
  task automatic fill4(input logic [7:0] a);
    order_i = 1'b0;
    step(1'b0, 1'b0, a, 4'h0, 0, 1'b0, '0);
    for (int i = 1; i < 4; i++) step(1'b1, 1'b1, '0, 4'h0, 0, 1'b0, mk(a + 8'(i - 1), '0));
    step(1'b0, 1'b1, '0, 4'h0, 1, 1'b0, mk(a + 8'd3, '0));
    for (int i = 0; i < 4; i++) ref_m[a + 8'(i)] = mk(a + 8'(i), '0);
  endtask

  task automatic t_reset;
    chk_off("R1 idle after reset");
  endtask

  task automatic t_write_read;
    logic [35:0] d, e, msk;
    d = 36'h1_2345_6789; e = 36'hA_BCDE_F012;
    step(1'b0, 1'b0, 8'h10, 4'h0, 0, 1'b0, '0);
    chk_off("R10 bus released after write");
    step(1'b0, 1'b1, 8'h10, 4'hf, 0, 1'b0, d);
    ref_m[8'h10] = d;
    chk_rd("R8 read right after write", d);
    chk_rd("R2 flow-through read", ref_m[8'h10]);
    // lanes 0 and 2 enabled
    step(1'b0, 1'b0, 8'h10, 4'b1010, 0, 1'b0, '0);
    step(1'b0, 1'b1, 8'h10, 4'hf, 0, 1'b0, e);
    msk = {9'h000, 9'h1ff, 9'h000, 9'h1ff};
    ref_m[8'h10] = (e & msk) | (d & ~msk);
    chk_rd("R3 byte-lane write", ref_m[8'h10]);
  endtask

  task automatic t_linear;
    order_i = 1'b0;
    step(1'b0, 1'b1, 8'h22, 4'hf, 0, 1'b0, '0);
    chk_rd("R4 beat0", ref_m[8'h22]);
    step(1'b1, 1'b1, '0, 4'hf, 0, 1'b0, '0);
    chk_rd("R4 beat1", ref_m[8'h23]);
    step(1'b1, 1'b1, '0, 4'hf, 0, 1'b0, '0);
    chk_rd("R4 beat2 wraps in group", ref_m[8'h20]);
    step(1'b1, 1'b1, '0, 4'hf, 0, 1'b0, '0);
    chk_rd("R4 beat3", ref_m[8'h21]);
    step(1'b1, 1'b1, '0, 4'hf, 0, 1'b0, '0);
    chk_rd("R11 fifth beat repeats first", ref_m[8'h22]);
  endtask

  task automatic t_interleave;
    order_i = 1'b1;
    step(1'b0, 1'b1, 8'h21, 4'hf, 0, 1'b0, '0);
    order_i = 1'b0; // sampled only at load
    chk_rd("R5 beat0", ref_m[8'h21]);
    step(1'b1, 1'b1, '0, 4'hf, 0, 1'b0, '0);
    chk_rd("R5 beat1", ref_m[8'h20]);
    step(1'b1, 1'b1, '0, 4'hf, 0, 1'b0, '0);
    chk_rd("R5 beat2", ref_m[8'h23]);
    step(1'b1, 1'b1, '0, 4'hf, 0, 1'b0, '0);
    chk_rd("R5 beat3", ref_m[8'h22]);
  endtask

  task automatic t_stall;
    logic [35:0] d;
    d = 36'h5_A5A5_0F0F;
    order_i = 1'b0;
    step(1'b0, 1'b1, 8'h20, 4'hf, 0, 1'b0, '0);
    step(1'b0, 1'b0, 8'h30, 4'h0, 0, 1'b1, '0);
    chk_rd("R6 stalled load ignored", ref_m[8'h20]);
    step(1'b1, 1'b1, '0, 4'hf, 0, 1'b0, '0);
    chk_rd("R6 burst resumes", ref_m[8'h21]);
    step(1'b0, 1'b0, 8'h40, 4'h0, 0, 1'b0, '0);
    step(1'b0, 1'b1, 8'h41, 4'hf, 0, 1'b1, 36'hF_FFFF_FFFF);
    step(1'b0, 1'b1, 8'h40, 4'hf, 0, 1'b0, d);
    ref_m[8'h40] = d;
    chk_rd("R6 write data taken at enabled edge", d);
  endtask

  task automatic t_deselect;
    logic [35:0] d;
    d = 36'h3_3C3C_7E7E;
    step(1'b0, 1'b0, 8'h50, 4'h0, 0, 1'b0, '0);
    step(1'b0, 1'b1, 8'h50, 4'hf, 2, 1'b0, d);
    ref_m[8'h50] = d;
    chk_off("R7 deselect idles bus");
    step(1'b1, 1'b1, '0, 4'hf, 0, 1'b0, '0);
    chk_off("R7 advance after deselect");
    step(1'b0, 1'b1, 8'h50, 4'hf, 0, 1'b0, '0);
    chk_rd("R7 pending write completed", d);
    step(1'b0, 1'b1, 8'h20, 4'hf, 0, 1'b0, '0);
    chk_rd("R2 read before deselect", ref_m[8'h20]);
    step(1'b0, 1'b1, 8'h20, 4'hf, 1, 1'b0, '0);
    chk_off("R7 cs_a deselect ends burst");
    step(1'b0, 1'b1, 8'h20, 4'hf, 3, 1'b0, '0);
    chk_off("R7 cs_c deselect");
  endtask

  task automatic t_oe;
    step(1'b0, 1'b1, 8'h23, 4'hf, 0, 1'b0, '0);
    oe_ni = 1'b1; #1;
    chk_off("R9 async output disable");
    oe_ni = 1'b0; #1;
    chk_rd("R9 output re-enabled", ref_m[8'h23]);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_ni = 1'b1;
    @(posedge clk); #2;
    t_reset();
    t_write_read();
    fill4(8'h20);
    t_linear();
    t_interleave();
    t_stall();
    t_deselect();
    t_oe();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule